// File: doc/BRIEF.md
# FIFO-Fed Pulse-Density DAC Peripheral

This block is a small register-mapped converter. Software writes sample words over a simple register bus. The words are queued in a data FIFO. The sample at the head of the queue is turned into a one-bit pulse-density stream by a first-order delta-sigma modulator. An external low-pass filter outside the block recovers the analog level.

Each queued sample is converted for a fixed number of modulator clocks, and then the next one takes its place. A control register starts and stops conversion and can flush the queue. A read-only register reports how many samples are waiting. The sample width is a parameter. An optional full-range mode widens every sample by one bit, so that the stream can reach a duty of 100 %.

Top module: `pdm_dac_periph`

## Requirements
- R1: After reset the control word reads 0, the occupancy reads 0, the data register reads 0 and `dac_out` is 0.
- R2: While the enable bit (control bit 0) is 0, `dac_out` stays 0, the modulator is held cleared and no sample is taken from the queue.
- R3: While the flush bit (control bit 1) is 1, the queue is held empty and sample writes are dropped. Writing 0 to the flush bit restores normal queueing.
- R4: The queue holds up to FIFO_DEPTH (16) samples, and the occupancy register (word address 2) counts each accepted write.
- R5: A sample written while the queue is full is discarded. The occupancy stays at FIFO_DEPTH, and the discarded value is never converted.
- R6: While the block is enabled and the queue is empty, `dac_out` is 0.
- R7: A read of the data register (word address 1) returns the head sample without removing it, and reading the occupancy has no side effect.
- R8: In normal mode the sample is bits SAMPLE_W-1:0 of the written word, and higher bits are ignored.
- R9: In full-range mode the sample is bits SAMPLE_W:0. The value 2^SAMPLE_W gives a stream of all ones. Values above 2^SAMPLE_W are undefined.
- R10: While enabled, each head sample drives the modulator for HOLD_CYCLES clocks. With HOLD_CYCLES = 2^SAMPLE_W, the number of ones in that window equals the sample value.
- R11: At the end of each conversion window the head is removed and the occupancy drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 control, 1 data, 2 occupancy |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| dac_out | output | 1 | Registered pulse-density output |

## Verification
The modulator is driven with a queue of sixteen samples and the ones are counted over each conversion window. The queue mixes the extremes 0 and full scale, the value 1, mid-scale, near-mid values and scattered codes. Matching counts at the extremes show that the carry forms the output. The odd and scattered values expose an accumulator that drops its remainder between windows. A word with set bits above the sample field separates correct masking from a sign or width slip. A second instance in full-range mode shows that the value 2^N saturates the stream. Holding a full queue while disabled and then overfilling it shows which write is lost. The drop shows up as a missing window in the scoreboard.

// File: rtl/pdm_dac_pkg.sv
// Shared definitions for the pulse-density DAC peripheral: register word
// addresses and control-bit positions.
package pdm_dac_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_OCC  = 2'd2
    } reg_addr_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_FLUSH_BIT = 1;
endpackage

// File: rtl/pdm_dac_fifo.sv
// Sample queue: circular buffer with an occupancy counter.
// Assumes DEPTH is a power of two. A push into a full queue is dropped.
// While clear is high the queue is held empty and pushes are ignored.
module pdm_dac_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign head    = mem[rd_ptr];

    // Storage write for accepted samples.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pdm_dac_mod.sv
// First-order delta-sigma modulator with a per-sample hold counter.
// The SAMPLE_W-bit accumulator plus the sample gives a sum one bit wider,
// and the top bit of that sum is the output. Each sample is used for
// HOLD_CYCLES clocks, then pop pulses. Assumes HOLD_CYCLES >= 2.
module pdm_dac_mod #(
    parameter int SAMPLE_W    = 8,
    parameter int DW          = 8,
    parameter int HOLD_CYCLES = 256,
    localparam int SW1        = SAMPLE_W + 1,
    localparam int HCW        = $clog2(HOLD_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          have_data,
    input  logic [DW-1:0] sample,
    output logic          bit_out,
    output logic          pop
);
    logic [SAMPLE_W-1:0] acc;
    logic [SW1-1:0]      sum;
    logic [HCW-1:0]      hold_cnt;
    logic                last;

    assign sum  = SW1'(acc) + SW1'(sample);
    assign last = (hold_cnt == HCW'(HOLD_CYCLES - 1));
    assign pop  = run && have_data && last;

    // Accumulate, emit the carry, and time the conversion window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc      <= '0;
            hold_cnt <= '0;
            bit_out  <= 1'b0;
        end else if (restart || !have_data) begin
            hold_cnt <= restart ? '0 : hold_cnt;
            bit_out  <= 1'b0;
        end else begin
            acc      <= sum[SAMPLE_W-1:0];
            bit_out  <= sum[SAMPLE_W];
            hold_cnt <= last ? '0 : hold_cnt + HCW'(1);
        end
    end
endmodule

// File: rtl/pdm_dac_periph.sv
// Register-mapped pulse-density DAC: control, data and occupancy words on
// a simple bus with a one-cycle write strobe and combinational reads.
// Assumes writes and reads have no side effects beyond those listed.
module pdm_dac_periph #(
    parameter int SAMPLE_W    = 8,
    parameter bit FULL_RANGE  = 1'b0,
    parameter int FIFO_DEPTH  = 16,
    parameter int HOLD_CYCLES = 256,
    localparam int DW         = SAMPLE_W + (FULL_RANGE ? 1 : 0),
    localparam int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        dac_out
);
    import pdm_dac_pkg::*;

    logic             ctrl_en, ctrl_flush;
    logic             wr_data, mod_pop, fifo_empty;
    logic [DW-1:0]    fifo_head;
    logic [OCC_W-1:0] fifo_count;

    assign wr_data = bus_wr && (bus_addr == REG_DATA);

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_flush <= 1'b0;
        end else if (bus_wr && bus_addr == REG_CTRL) begin
            ctrl_en    <= bus_wdata[CTRL_EN_BIT];
            ctrl_flush <= bus_wdata[CTRL_FLUSH_BIT];
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT]    = ctrl_en;
                bus_rdata[CTRL_FLUSH_BIT] = ctrl_flush;
            end
            REG_DATA: bus_rdata = fifo_empty ? 32'd0 : 32'(fifo_head);
            REG_OCC:  bus_rdata = 32'(fifo_count);
            default:  bus_rdata = '0;
        endcase
    end

    pdm_dac_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctrl_flush),
        .push      (wr_data),
        .push_data (bus_wdata[DW-1:0]),
        .pop       (mod_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    pdm_dac_mod #(.SAMPLE_W(SAMPLE_W), .DW(DW), .HOLD_CYCLES(HOLD_CYCLES)) u_mod (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_en),
        .restart   (ctrl_flush),
        .have_data (!fifo_empty),
        .sample    (fifo_head),
        .bit_out   (dac_out),
        .pop       (mod_pop)
    );
endmodule

// File: rtl/pdm_dac_checker.sv
// Property checker for pdm_dac_periph, attached by bind.
module pdm_dac_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          flush,
    input logic [CW-1:0] occ,
    input logic          dac_out
);
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !dac_out);

    p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> occ == '0);

    p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && !en && !flush) |=> occ == CW'(DEPTH));

    p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> !dac_out);

    p_no_drain_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush && occ != '0) |=> occ >= $past(occ));
endmodule

bind pdm_dac_periph pdm_dac_checker #(.DEPTH(FIFO_DEPTH), .CW(OCC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .flush   (ctrl_flush),
    .occ     (fifo_count),
    .dac_out (dac_out)
);

// File: tb/pdm_dac_periph_bench.sv
`timescale 1ns/1ps
module pdm_dac_periph_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        sel = 1'b0;
    logic [31:0] rd0, rd1, bus_rdata;
    logic        d0, d1, dac_mon;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    int hold_len = 256;
    int mask = 32'hFF;
    bit mon_done = 1'b0;
    event mon_go;

    always #10 clk = ~clk;

    pdm_dac_periph u_pdm_dac_periph (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr && !sel),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .dac_out(d0));

    pdm_dac_periph #(.SAMPLE_W(4), .FULL_RANGE(1'b1), .HOLD_CYCLES(16)) u_pdm_dac_periph_fr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr && sel),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .dac_out(d1));

    assign bus_rdata = sel ? rd1 : rd0;
    assign dac_mon   = sel ? d1 : d0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    // Driver: write a sample and record it if the queue can accept it.
    task automatic push_sample(input int v);
        if (exp_q.size() < 16) exp_q.push_back(v & mask);
        bus_write(2'd1, 32'(v));
    endtask

    // Monitor: count ones per conversion window and compare with the queue.
    initial begin
        forever begin
            @(mon_go);
            while (exp_q.size() > 0) begin
                int exp_v, ones, occ;
                exp_v = exp_q.pop_front();
                ones = 0;
                for (int c = 0; c < hold_len; c++) begin
                    @(posedge clk);
                    @(negedge clk);
                    if (dac_mon) ones++;
                end
                check(ones == exp_v, "R10 ones in window", ones, exp_v);
                bus_addr = 2'd2;
                #1 occ = int'(bus_rdata);
                check(occ == exp_q.size(), "R11 occupancy after window", occ, exp_q.size());
            end
            mon_done = 1'b1;
        end
    end

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, v); check(v == 0, "R1 control", v, 0);
        bus_read(2'd2, v); check(v == 0, "R1 occupancy", v, 0);
        bus_read(2'd1, v); check(v == 0, "R1 data", v, 0);
        check(d0 == 1'b0, "R1 dac_out", int'(d0), 0);

        // R2 / R7: queue while disabled
        bus_write(2'd1, 32'h11); bus_write(2'd1, 32'h22); bus_write(2'd1, 32'h33);
        bus_read(2'd2, v); check(v == 3, "R4 occupancy counts", v, 3);
        bus_read(2'd1, v); check(v == 32'h11, "R7 head read", v, 32'h11);
        bus_read(2'd1, v); check(v == 32'h11, "R7 head read no pop", v, 32'h11);
        bus_read(2'd2, v); check(v == 3, "R7 reads leave occupancy", v, 3);
        errs = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (d0) errs++;
        end
        check(errs == 0, "R2 output zero while disabled", errs, 0);
        bus_read(2'd2, v); check(v == 3, "R2 no drain while disabled", v, 3);

        // R3 flush
        bus_write(2'd0, 32'h2);
        bus_read(2'd2, v); check(v == 0, "R3 flush empties", v, 0);
        bus_write(2'd1, 32'h44);
        bus_read(2'd2, v); check(v == 0, "R3 write dropped during flush", v, 0);
        bus_read(2'd0, v); check(v == 2, "R3 flush bit reads back", v, 2);
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'h66);
        bus_read(2'd2, v); check(v == 1, "R3 normal after flush release", v, 1);
        bus_write(2'd0, 32'h2);
        bus_write(2'd0, 32'h0);

        // R4 / R5 / R8: fill, overfill
        push_sample(32'h1C0);
        for (int k = 1; k < 16; k++) begin
            case (k)
                1: push_sample(0);
                2: push_sample(255);
                3: push_sample(1);
                4: push_sample(128);
                5: push_sample(127);
                6: push_sample(254);
                default: push_sample((k * 37 + 3) & 255);
            endcase
        end
        bus_read(2'd2, v); check(v == 16, "R4 full depth", v, 16);
        push_sample(32'h55);
        bus_read(2'd2, v); check(v == 16, "R5 overfill dropped", v, 16);
        bus_read(2'd1, v); check(v == 32'hC0, "R8 upper bits masked", v, 32'hC0);

        // R10 / R11: convert all sixteen
        mon_done = 1'b0;
        bus_write(2'd0, 32'h1);
        -> mon_go;
        wait (mon_done);

        // R6: enabled but empty
        errs = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (d0) errs++;
        end
        check(errs == 0, "R6 output zero when empty", errs, 0);
        bus_write(2'd0, 32'h0);

        // R9: full-range instance
        sel = 1'b1; hold_len = 16; mask = 32'h1F;
        push_sample(16);
        push_sample(32'h25);
        bus_read(2'd1, v); check(v == 16, "R9 full-range head", v, 16);
        mon_done = 1'b0;
        bus_write(2'd0, 32'h1);
        -> mon_go;
        wait (mon_done);
        check(exp_q.size() == 0, "R9 full-range windows done", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule